// File: doc/BRIEF.md
# Burst Slave DMA Channel

A single DMA channel that moves data between a fixed peripheral FIFO and memory in whole 32-byte bursts. Software programs a memory-side start address, a count of 32-byte units and a byte-valid mask for the final burst, then sets the enable bit in the control word. The channel runs until the count is exhausted, flags transfer end and raises a level interrupt.

The channel runs in either direction. In peripheral-to-memory mode it takes one 32-byte beat from the FIFO through a valid/ready handshake and writes it to memory. In memory-to-peripheral mode it reads one burst from memory and pushes it to the FIFO. The memory side uses a simple request/acknowledge port. The live address and count registers advance as the transfer proceeds, so software can read back its progress.

The peripheral can report an empty or short condition. When detection of this condition is enabled, the channel latches a null status. Software can then force a normal transfer end. A global enable gates all data movement, and a soft-reset register holds the channel idle.

Top module: `burst_dma_chan`

## Requirements
- R1: After reset every register reads 0, `irq_o` is 0 and no memory request is issued.
- R2: In peripheral-to-memory mode (control bit8 = 0), each unit takes one FIFO beat and issues one memory write. The first write goes to the destination register (offset 0x24) and each later write is 32 bytes higher. After each burst the live destination register rises by 32 and the count (offset 0x28, low 24 bits) falls by 1.
- R3: In memory-to-peripheral mode (control bit8 = 1), each unit issues one memory read at the source register (offset 0x20) and then pushes one beat. The live source address steps by 32 per burst.
- R4: Every burst except the last carries all 32 byte strobes. On the last burst, strobe bit i (byte i) equals bit 31-i of the final mask (offset 0x38), so the mask is MSB-aligned.
- R5: In the control word (offset 0x34), bit1 (end) becomes 1 with bit0 (enable) still 1 once the count reaches 0. A transfer started with a count of 0 ends at once and moves no data.
- R6: `irq_o` is 1 when bit5 (interrupt enable) is 1 and bit1 or bit2 (stopped) is 1, or whenever bit12 (null) is 1.
- R7: Control bits 1, 2 and 12 and the address-error bit (bit1 at offset 0x60) clear only when 0 is written to them. Writing 1 leaves them unchanged.
- R8: While the master enable (bit0 at offset 0x60) is 0, no FIFO beat is accepted and no memory request starts. Setting it lets a pending transfer complete.
- R9: With bit16 (null detect enable) set, a null report from the peripheral during a busy transfer sets bit12. Writing bit24 = 1 while busy ends the transfer at the next burst boundary by setting bit1.
- R10: Enabling the channel while the source or destination address has any of its low 5 bits set sets the address-error bit, sets bit2 and leaves bit0 at 0.
- R11: While the soft-reset bit (bit0 at offset 0x08) is 1, bits 0, 1, 2 and 12 read 0 and no data moves. Once the bit is cleared, the channel works again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Level interrupt |
| fifo_valid_i | input | 1 | Peripheral beat available |
| fifo_data_i | input | 256 | Peripheral beat data |
| fifo_ready_o | output | 1 | Channel accepts the beat |
| fifo_null_i | input | 1 | Peripheral empty/short report |
| push_valid_o | output | 1 | Beat toward peripheral valid |
| push_data_o | output | 256 | Beat toward peripheral data |
| push_strb_o | output | 32 | Byte valid for the pushed beat |
| push_ready_i | input | 1 | Peripheral accepts the beat |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Burst address |
| mem_wdata_o | output | 256 | Write data |
| mem_strb_o | output | 32 | Write byte strobes |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 256 | Read data |

## Verification
The main transfer runs from a vector table in both directions. The table varies the unit count and the final mask: a full mask, a half mask, a single-byte mask and a mask with only the last byte cleared. This separates a reversed or unreversed mask, trimming applied to the wrong burst, and an off-by-one in the count. The bench models memory and the peripheral, and checks every burst address against the expected 32-byte stride. It also checks the total byte count and the final live address. Directed cases then cover a zero count, a misaligned address, the master enable held low, the null-then-force-end path and soft reset part way through a transfer.

// File: rtl/bdma_pkg.sv
package bdma_pkg;
  typedef enum logic [2:0] {S_IDLE, S_FILL, S_WR, S_RD, S_PUSH} eng_state_e;

  localparam logic [7:0] OFF_SWR = 8'h08;
  localparam logic [7:0] OFF_SRC = 8'h20;
  localparam logic [7:0] OFF_DST = 8'h24;
  localparam logic [7:0] OFF_CNT = 8'h28;
  localparam logic [7:0] OFF_CTL = 8'h34;
  localparam logic [7:0] OFF_MSK = 8'h38;
  localparam logic [7:0] OFF_OPR = 8'h60;

  localparam int B_DE    = 0;
  localparam int B_TE    = 1;
  localparam int B_SP    = 2;
  localparam int B_IE    = 5;
  localparam int B_TSZ   = 6;
  localparam int B_DIR   = 8;
  localparam int B_NULL  = 12;
  localparam int B_NULLE = 16;
  localparam int B_FTE   = 24;
endpackage

// File: rtl/bdma_engine.sv
module bdma_engine
  import bdma_pkg::*;
#(
  parameter int BURST_BYTES = 32,
  parameter int AW          = 32,
  localparam int DW         = 8 * BURST_BYTES
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   go_i,
  input  logic                   abort_i,
  input  logic                   dir_i,
  input  logic                   last_i,
  input  logic [BURST_BYTES-1:0] mask_i,
  input  logic [AW-1:0]          src_i,
  input  logic [AW-1:0]          dst_i,
  output logic                   beat_done_o,
  output logic                   boundary_o,
  input  logic                   fifo_valid_i,
  input  logic [DW-1:0]          fifo_data_i,
  output logic                   fifo_ready_o,
  output logic                   push_valid_o,
  output logic [DW-1:0]          push_data_o,
  output logic [BURST_BYTES-1:0] push_strb_o,
  input  logic                   push_ready_i,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [AW-1:0]          mem_addr_o,
  output logic [DW-1:0]          mem_wdata_o,
  output logic [BURST_BYTES-1:0] mem_strb_o,
  input  logic                   mem_ack_i,
  input  logic [DW-1:0]          mem_rdata_i
);
  eng_state_e state_q, state_d;
  logic [DW-1:0] data_q;
  logic [BURST_BYTES-1:0] mask_rev, strb;

  // mask is MSB-aligned: top bit belongs to byte 0
  for (genvar i = 0; i < BURST_BYTES; i++) begin : g_rev
    assign mask_rev[i] = mask_i[BURST_BYTES-1-i];
  end
  assign strb = last_i ? mask_rev : '1;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (go_i && !abort_i) state_d = dir_i ? S_RD : S_FILL;
      S_FILL: if (abort_i || !go_i) state_d = S_IDLE;
              else if (fifo_valid_i) state_d = S_WR;
      S_WR:   if (abort_i || mem_ack_i) state_d = S_IDLE;
      S_RD:   if (abort_i) state_d = S_IDLE;
              else if (mem_ack_i) state_d = S_PUSH;
      S_PUSH: if (abort_i || push_ready_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (fifo_ready_o && fifo_valid_i) data_q <= fifo_data_i;
      else if (state_q == S_RD && mem_ack_i) data_q <= mem_rdata_i;
    end
  end

  assign fifo_ready_o = (state_q == S_FILL) && go_i && !abort_i;
  assign mem_req_o    = (state_q == S_WR) || (state_q == S_RD);
  assign mem_we_o     = (state_q == S_WR);
  assign mem_addr_o   = dir_i ? src_i : dst_i;
  assign mem_wdata_o  = data_q;
  assign mem_strb_o   = strb;
  assign push_valid_o = (state_q == S_PUSH);
  assign push_data_o  = data_q;
  assign push_strb_o  = strb;
  assign boundary_o   = (state_q == S_IDLE) || (state_q == S_FILL);
  assign beat_done_o  = !abort_i && (((state_q == S_WR) && mem_ack_i) ||
                                     ((state_q == S_PUSH) && push_ready_i));

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && !abort_i) |=> (mem_req_o && $stable(mem_addr_o)));
endmodule

// File: rtl/burst_dma_chan.sv
module burst_dma_chan
  import bdma_pkg::*;
#(
  parameter int BURST_BYTES = 32,
  parameter int AW          = 32,
  parameter int CW          = 24,
  localparam int DW         = 8 * BURST_BYTES,
  localparam int LOW_BITS   = $clog2(BURST_BYTES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   reg_we_i,
  input  logic [7:0]             reg_addr_i,
  input  logic [31:0]            reg_wdata_i,
  output logic [31:0]            reg_rdata_o,
  output logic                   irq_o,
  input  logic                   fifo_valid_i,
  input  logic [DW-1:0]          fifo_data_i,
  output logic                   fifo_ready_o,
  input  logic                   fifo_null_i,
  output logic                   push_valid_o,
  output logic [DW-1:0]          push_data_o,
  output logic [BURST_BYTES-1:0] push_strb_o,
  input  logic                   push_ready_i,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [AW-1:0]          mem_addr_o,
  output logic [DW-1:0]          mem_wdata_o,
  output logic [BURST_BYTES-1:0] mem_strb_o,
  input  logic                   mem_ack_i,
  input  logic [DW-1:0]          mem_rdata_i
);
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic [BURST_BYTES-1:0] mask_q;
  logic [1:0] tsz_q;
  logic de_q, te_q, sp_q, ie_q, dir_q, nulle_q, null_q, fte_pend_q;
  logic dme_q, ae_q, swr_q;
  logic go, busy, beat_done, boundary, te_set, null_set, misaligned;

  assign busy       = de_q && !te_q;
  assign go         = busy && dme_q && !swr_q && (cnt_q != '0) && !fte_pend_q;
  assign misaligned = (src_q[LOW_BITS-1:0] | dst_q[LOW_BITS-1:0]) != '0;
  assign te_set     = (beat_done && cnt_q == CW'(1)) ||
                      (busy && dme_q && !swr_q && cnt_q == '0) ||
                      (fte_pend_q && busy && boundary);
  assign null_set   = nulle_q && busy && fifo_null_i && !swr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0; dst_q <= '0; cnt_q <= '0; mask_q <= '0; tsz_q <= '0;
      de_q <= 1'b0; te_q <= 1'b0; sp_q <= 1'b0; ie_q <= 1'b0; dir_q <= 1'b0;
      nulle_q <= 1'b0; null_q <= 1'b0; fte_pend_q <= 1'b0;
      dme_q <= 1'b0; ae_q <= 1'b0; swr_q <= 1'b0;
    end else begin
      if (reg_we_i) begin
        case (reg_addr_i)
          OFF_SWR: swr_q  <= reg_wdata_i[0];
          OFF_SRC: src_q  <= reg_wdata_i[AW-1:0];
          OFF_DST: dst_q  <= reg_wdata_i[AW-1:0];
          OFF_CNT: cnt_q  <= reg_wdata_i[CW-1:0];
          OFF_MSK: mask_q <= reg_wdata_i[BURST_BYTES-1:0];
          OFF_OPR: begin
            dme_q <= reg_wdata_i[0];
            ae_q  <= ae_q & reg_wdata_i[1];
          end
          OFF_CTL: begin
            de_q    <= reg_wdata_i[B_DE];
            te_q    <= te_q & reg_wdata_i[B_TE];
            sp_q    <= sp_q & reg_wdata_i[B_SP];
            null_q  <= null_q & reg_wdata_i[B_NULL];
            ie_q    <= reg_wdata_i[B_IE];
            tsz_q   <= reg_wdata_i[B_TSZ+1:B_TSZ];
            dir_q   <= reg_wdata_i[B_DIR];
            nulle_q <= reg_wdata_i[B_NULLE];
            if (!reg_wdata_i[B_DE]) fte_pend_q <= 1'b0;
            else if (reg_wdata_i[B_FTE] && busy) fte_pend_q <= 1'b1;
            if (reg_wdata_i[B_DE] && !de_q && misaligned) begin
              de_q <= 1'b0;
              sp_q <= 1'b1;
              ae_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
      if (beat_done) begin
        if (dir_q) src_q <= src_q + AW'(BURST_BYTES);
        else       dst_q <= dst_q + AW'(BURST_BYTES);
        cnt_q <= cnt_q - CW'(1);
      end
      if (te_set) begin
        te_q       <= 1'b1;
        fte_pend_q <= 1'b0;
      end
      if (null_set) null_q <= 1'b1;
      if (swr_q) begin
        de_q <= 1'b0; te_q <= 1'b0; sp_q <= 1'b0; null_q <= 1'b0; fte_pend_q <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFF_SWR: reg_rdata_o[0] = swr_q;
      OFF_SRC: reg_rdata_o[AW-1:0] = src_q;
      OFF_DST: reg_rdata_o[AW-1:0] = dst_q;
      OFF_CNT: reg_rdata_o[CW-1:0] = cnt_q;
      OFF_MSK: reg_rdata_o[BURST_BYTES-1:0] = mask_q;
      OFF_OPR: reg_rdata_o[1:0] = {ae_q, dme_q};
      OFF_CTL: begin
        reg_rdata_o[B_DE]    = de_q;
        reg_rdata_o[B_TE]    = te_q;
        reg_rdata_o[B_SP]    = sp_q;
        reg_rdata_o[B_IE]    = ie_q;
        reg_rdata_o[B_TSZ+1:B_TSZ] = tsz_q;
        reg_rdata_o[B_DIR]   = dir_q;
        reg_rdata_o[B_NULL]  = null_q;
        reg_rdata_o[B_NULLE] = nulle_q;
      end
      default: ;
    endcase
  end

  assign irq_o = (ie_q && (te_q || sp_q)) || null_q;

  bdma_engine #(.BURST_BYTES(BURST_BYTES), .AW(AW)) u_engine (
    .clk_i, .rst_ni,
    .go_i(go), .abort_i(swr_q), .dir_i(dir_q), .last_i(cnt_q == CW'(1)),
    .mask_i(mask_q), .src_i(src_q), .dst_i(dst_q),
    .beat_done_o(beat_done), .boundary_o(boundary),
    .fifo_valid_i, .fifo_data_i, .fifo_ready_o,
    .push_valid_o, .push_data_o, .push_strb_o, .push_ready_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_strb_o,
    .mem_ack_i, .mem_rdata_i
  );

  p_dst_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_done && !dir_q && !reg_we_i) |=> dst_q == $past(dst_q) + AW'(BURST_BYTES));
  p_te_with_de_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(te_q) |-> $past(de_q));
  p_fifo_needs_dme_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_ready_o |-> dme_q);
  p_req_needs_dme_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(dme_q));
  p_ae_stops_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ae_q) |-> !de_q);
endmodule

// File: tb/burst_dma_chan_test.sv
`timescale 1ns/1ps
module burst_dma_chan_test;
  localparam logic [7:0] A_SWR = 8'h08, A_SRC = 8'h20, A_DST = 8'h24, A_CNT = 8'h28,
                         A_CTL = 8'h34, A_MSK = 8'h38, A_OPR = 8'h60;
  localparam logic [31:0] C_DE = 32'h1, C_TE = 32'h2, C_SP = 32'h4, C_IE = 32'h20,
                          C_TSZ = 32'h80, C_DIR = 32'h100, C_NULL = 32'h1000,
                          C_NULLE = 32'h10000, C_FTE = 32'h100_0000;

  typedef struct packed {
    logic        dir;
    logic [7:0]  units;
    logic [31:0] mask;
    logic [15:0] bytes;
    logic [31:0] lstrb;
  } vec_t;
  localparam vec_t VECS [4] = '{
    '{1'b0, 8'd3, 32'hFFFF_FFFF, 16'd96, 32'hFFFF_FFFF},
    '{1'b0, 8'd2, 32'hFFFF_0000, 16'd48, 32'h0000_FFFF},
    '{1'b1, 8'd4, 32'h8000_0000, 16'd97, 32'h0000_0001},
    '{1'b1, 8'd1, 32'hFFFF_FFFE, 16'd31, 32'h7FFF_FFFF}
  };

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic we = 0; logic [7:0] addr = 0; logic [31:0] wdata = 0; logic [31:0] rdata;
  logic irq, fifo_ready, push_valid, mem_req, mem_we;
  logic fifo_valid = 0, fifo_null = 0, push_ready = 0, mem_ack = 0;
  logic [255:0] push_data, mem_wdata, mem_rdata = '0;
  logic [31:0] push_strb, mem_strb, mem_addr;

  burst_dma_chan uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .fifo_valid_i(fifo_valid),
    .fifo_data_i({8{32'hA5A5_0001}}), .fifo_ready_o(fifo_ready), .fifo_null_i(fifo_null),
    .push_valid_o(push_valid), .push_data_o(push_data), .push_strb_o(push_strb),
    .push_ready_i(push_ready), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_strb_o(mem_strb), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  int n_chk = 0, n_err = 0;
  int mem_beats = 0, push_beats = 0, byte_cnt = 0, addr_err = 0, cycles = 0;
  logic [31:0] last_strb = 0, exp_base = 0;

  // memory and peripheral models, driven away from the active edge
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      mem_ack = 1;
      mem_rdata = {8{mem_addr}};
      if (mem_addr != exp_base + 32 * mem_beats) addr_err++;
      mem_beats++;
      if (mem_we) begin byte_cnt += $countones(mem_strb); last_strb = mem_strb; end
    end
    if (push_ready) push_ready = 0;
    else if (push_valid) begin
      push_ready = 1; push_beats++;
      byte_cnt += $countones(push_strb); last_strb = push_strb;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog (R1..) act=hung exp=done");
      summary();
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic wait_te(input int max);
    logic [31:0] v;
    for (int i = 0; i < max; i++) begin
      rd(A_CTL, v);
      if (v[1]) return;
    end
  endtask

  task automatic clr_counts(input logic [31:0] base);
    mem_beats = 0; push_beats = 0; byte_cnt = 0; addr_err = 0; last_strb = 0; exp_base = base;
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(A_CTL, v); check("R1 ctl", v, 0);
    rd(A_OPR, v); check("R1 opr", v, 0);
    rd(A_CNT, v); check("R1 cnt", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 req", {31'b0, mem_req}, 0);

    wr(A_OPR, 32'h1);
    for (int k = 0; k < 4; k++) begin
      clr_counts(32'h1000);
      fifo_valid = 1;
      wr(A_SRC, VECS[k].dir ? 32'h1000 : 32'h0);
      wr(A_DST, VECS[k].dir ? 32'h0 : 32'h1000);
      wr(A_CNT, {24'b0, VECS[k].units});
      wr(A_MSK, VECS[k].mask);
      wr(A_CTL, C_DE | C_IE | C_TSZ | (VECS[k].dir ? C_DIR : 32'h0));
      wait_te(400);
      rd(A_CTL, v);
      check("R5 te+de", v & (C_DE | C_TE), C_DE | C_TE);
      check("R6 irq on te", {31'b0, irq}, 1);
      check("R4 bytes", byte_cnt, {16'b0, VECS[k].bytes});
      check("R4 last strobe", last_strb, VECS[k].lstrb);
      check(VECS[k].dir ? "R3 beats" : "R2 beats",
            VECS[k].dir ? push_beats : mem_beats, {24'b0, VECS[k].units});
      check("R2/R3 addr stride", addr_err, 0);
      rd(VECS[k].dir ? A_SRC : A_DST, v);
      check(VECS[k].dir ? "R3 live src" : "R2 live dst", v, 32'h1000 + 32 * VECS[k].units);
      rd(A_CNT, v); check("R2 count", v, 0);
      wr(A_CTL, C_IE | C_TE);  // writing 1 keeps TE
      rd(A_CTL, v); check("R7 te kept", v & C_TE, C_TE);
      wr(A_CTL, 32'h0);
      check("R7 irq cleared", {31'b0, irq}, 0);
      rd(A_CTL, v); check("R7 te cleared", v & C_TE, 0);
    end

    // R8 master enable low
    clr_counts(32'h2000);
    wr(A_OPR, 32'h0);
    wr(A_SRC, 0); wr(A_DST, 32'h2000); wr(A_CNT, 2); wr(A_MSK, 32'hFFFF_FFFF);
    wr(A_CTL, C_DE);
    repeat (20) @(negedge clk);
    check("R8 no beats", mem_beats, 0);
    check("R8 fifo not ready", {31'b0, fifo_ready}, 0);
    wr(A_OPR, 32'h1);
    wait_te(200);
    check("R8 resumed beats", mem_beats, 2);
    wr(A_CTL, 0);

    // R5 zero count
    clr_counts(32'h2000);
    wr(A_DST, 32'h2000); wr(A_CNT, 0);
    wr(A_CTL, C_DE);
    repeat (3) @(negedge clk);
    rd(A_CTL, v); check("R5 zero count te", v & (C_DE | C_TE), C_DE | C_TE);
    check("R5 zero count no data", mem_beats, 0);
    wr(A_CTL, 0);

    // R10 misaligned address
    wr(A_DST, 32'h1004); wr(A_CNT, 1);
    wr(A_CTL, C_DE | C_IE | C_TSZ);
    rd(A_OPR, v); check("R10 ae set", v, 32'h3);
    rd(A_CTL, v); check("R10 ctl", v, C_SP | C_IE | C_TSZ);
    check("R6 irq on sp", {31'b0, irq}, 1);
    wr(A_CTL, 0);
    check("R7 sp clear irq", {31'b0, irq}, 0);
    wr(A_OPR, 32'h3);
    rd(A_OPR, v); check("R7 ae kept", v, 32'h3);
    wr(A_OPR, 32'h1);
    rd(A_OPR, v); check("R7 ae cleared", v, 32'h1);

    // R9 null then force end
    clr_counts(32'h2000);
    fifo_valid = 0;
    wr(A_DST, 32'h2000); wr(A_CNT, 2);
    wr(A_CTL, C_DE | C_NULLE);
    repeat (3) @(negedge clk);
    check("R6 no irq before null", {31'b0, irq}, 0);
    fifo_null = 1; @(negedge clk); fifo_null = 0;
    rd(A_CTL, v); check("R9 null set", v, C_DE | C_NULLE | C_NULL);
    check("R6 irq on null", {31'b0, irq}, 1);
    wr(A_CTL, C_DE | C_NULLE | C_FTE);
    repeat (3) @(negedge clk);
    rd(A_CTL, v); check("R9 force end", v, C_DE | C_TE | C_NULLE);
    check("R9 irq off (ie=0)", {31'b0, irq}, 0);
    check("R9 no data", mem_beats, 0);
    wr(A_CTL, 0);

    // R11 soft reset
    clr_counts(32'h3000);
    wr(A_DST, 32'h3000); wr(A_CNT, 4);
    wr(A_CTL, C_DE);
    wr(A_SWR, 32'h1);
    rd(A_CTL, v); check("R11 ctl cleared", v, 0);
    fifo_valid = 1;
    repeat (10) @(negedge clk);
    check("R11 no beats", mem_beats, 0);
    check("R11 fifo idle", {31'b0, fifo_ready}, 0);
    wr(A_SWR, 32'h0);
    wr(A_CTL, C_DE | C_IE);
    wait_te(300);
    check("R11 works after release", mem_beats, 4);
    rd(A_DST, v); check("R11 dst after release", v, 32'h3080);
    wr(A_CTL, 0);

    summary();
  end
endmodule